// File: doc/BRIEF.md
# Program Counter Next-Address Sequencer

This block holds the program counter of a 16-bit, byte-addressed RISC core and works out its value for the next cycle. Each cycle in which it is enabled, the PC does one of three things. It moves on to the next instruction, two bytes further on. It takes a relative branch by a signed word displacement. It loads an absolute target, which serves jumps, calls and returns. The pipeline around the block evaluates branch conditions and forms effective addresses. The block only receives the outcome of those steps.

The datapath has a single adder. A small select in front of the adder picks its second operand: either the constant two or the doubled, sign-extended displacement. The output stage is an add-or-load cell. When a jump is taken, the carry chain is held idle so that the loaded target passes through unchanged. This costs one adder and two narrow selects, where a simpler layout would need two adders and a three-way select.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high at a rising clock edge, the PC becomes 0x0000 on that edge, whatever the other inputs are.
- R2: When `en` is low and `rst` is low, the PC keeps its value and `jmp`, `br_take`, `br_ofs` and `jmp_addr` have no effect on it.
- R3: When enabled with `jmp` and `br_take` both low, the next PC is the current PC plus 2, modulo 2^16.
- R4: When enabled with `br_take` high and `jmp` low, the 8-bit `br_ofs` is read as a two's-complement word count. It is doubled by appending a zero LSB, sign-extended to 16 bits and added to the PC modulo 2^16. This gives a reach of -256 to +254 bytes.
- R5: When enabled with `jmp` high, the next PC is `jmp_addr` with bit 0 forced to zero. Bit 0 of `jmp_addr` is ignored.
- R6: `jmp` takes priority over `br_take`, and `br_take` takes priority over the sequential step.
- R7: Bit 0 of `pc` is zero in every cycle.
- R8: When the load path is selected, no carry is raised anywhere in the shared adder chain. The loaded target therefore appears bit-exact, even when the current PC and the addend are mostly ones.
- R9: The sequential step and a branch both wrap across the top of the address space: 0xFFFE plus 2 gives 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; low holds the PC |
| br_take | input | 1 | Taken relative branch this cycle |
| br_ofs | input | 8 | Signed branch displacement in words |
| jmp | input | 1 | Load the absolute target this cycle |
| jmp_addr | input | 16 | Absolute target byte address |
| pc | output | 16 | Current program counter |

## Verification
The hardest case to set up is a jump taken while the adder's own operands would generate long carries. A stray carry in the add-or-load cell only shows when the current PC, the selected addend and the target all have ones in matching places. To get there, the stimulus first jumps to the top of memory. It then asserts a jump together with a taken all-ones branch and a target of alternating bits, so a corrupted bit would show at the output. The displacement extremes and the wrap from 0xFFFE are reached by first jumping to a chosen PC and then stepping or branching from it.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    parameter int unsigned PC_W   = 16;
    parameter int unsigned DISP_W = 8;
    parameter int unsigned STEP   = 2;

    localparam int unsigned EXT_W = PC_W - DISP_W - 1;

    typedef logic [PC_W-1:0]   pc_t;
    typedef logic [DISP_W-1:0] disp_t;

    typedef enum logic [1:0] {
        SRC_STEP   = 2'd0,
        SRC_BRANCH = 2'd1,
        SRC_LOAD   = 2'd2
    } next_src_e;

    typedef struct packed {
        logic  adv;
        logic  take_br;
        logic  take_jmp;
        disp_t ofs;
        pc_t   target;
    } seq_req_t;

    typedef struct packed {
        next_src_e src;
        logic      add_mode;
        logic      use_disp;
        logic      adv;
    } seq_ctl_t;

    function automatic pc_t widen_disp(input disp_t d);
        return {{EXT_W{d[DISP_W-1]}}, d, 1'b0};
    endfunction

    function automatic pc_t align_even(input pc_t a);
        return a & ~pc_t'(1);
    endfunction

endpackage

// File: rtl/pcseq_decode.sv
module pcseq_decode
    import pcseq_pkg::*;
(
    input  seq_req_t req,
    output seq_ctl_t ctl
);
    next_src_e src;

    always_comb begin
        if (req.take_jmp)
            src = SRC_LOAD;
        else if (req.take_br)
            src = SRC_BRANCH;
        else
            src = SRC_STEP;
    end

    always_comb begin
        ctl.src      = src;
        ctl.add_mode = (src != SRC_LOAD);
        ctl.use_disp = req.take_br;
        ctl.adv      = req.adv;
    end

endmodule

// File: rtl/pcseq_addend.sv
module pcseq_addend
    import pcseq_pkg::*;
(
    input  logic  use_disp,
    input  disp_t ofs,
    output pc_t   addend
);
    pc_t disp_ext;

    always_comb begin
        disp_ext = widen_disp(ofs);
        addend   = use_disp ? disp_ext : pc_t'(STEP);
    end

endmodule

// File: rtl/pcseq_addload.sv
module pcseq_addload
    import pcseq_pkg::*;
#(
    parameter int unsigned W = PC_W
) (
    input  logic         add_mode,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] k,
    output logic [W-1:0] y,
    output logic [W-1:0] carry
);
    logic [W:0] c;

    assign c[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_cell
        logic sel;
        logic gen;
        assign sel      = add_mode ? (a[i] ^ b[i]) : k[i];
        assign gen      = add_mode & a[i];
        assign c[i+1]   = sel ? c[i] : gen;
        assign y[i]     = sel ^ c[i];
    end

    assign carry = c[W:1];

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic        br_take,
    input  logic [7:0]  br_ofs,
    input  logic        jmp,
    input  logic [15:0] jmp_addr,
    output logic [15:0] pc
);
    seq_req_t req;
    seq_ctl_t ctl;
    pc_t      pc_q;
    pc_t      addend;
    pc_t      pc_nxt;
    pc_t      chain_carry;
    logic     load_path;

    always_comb begin
        req.adv      = en;
        req.take_br  = br_take;
        req.take_jmp = jmp;
        req.ofs      = br_ofs;
        req.target   = align_even(jmp_addr);
    end

    pcseq_decode u_dec (
        .req (req),
        .ctl (ctl)
    );

    pcseq_addend u_addend (
        .use_disp (ctl.use_disp),
        .ofs      (req.ofs),
        .addend   (addend)
    );

    pcseq_addload #(.W(PC_W)) u_al (
        .add_mode (ctl.add_mode),
        .a        (pc_q),
        .b        (addend),
        .k        (req.target),
        .y        (pc_nxt),
        .carry    (chain_carry)
    );

    assign load_path = (ctl.src == SRC_LOAD);

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= '0;
        else if (ctl.adv)
            pc_q <= pc_nxt;
    end

    assign pc = pc_q;

endmodule

// File: rtl/pcseq_checker.sv
module pcseq_checker (
    input logic        clk,
    input logic        rst,
    input logic        en,
    input logic        br_take,
    input logic [7:0]  br_ofs,
    input logic        jmp,
    input logic [15:0] jmp_addr,
    input logic [15:0] pc,
    input logic        load_path,
    input logic [15:0] chain_carry
);
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> pc == $past(pc));

    a_r3_step: assert property (@(posedge clk) disable iff (rst)
        (en && !jmp && !br_take) |=> pc == 16'($past(pc) + 16'd2));

    a_r4_branch: assert property (@(posedge clk) disable iff (rst)
        (en && !jmp && br_take) |=>
            pc == 16'($past(pc) + {{7{$past(br_ofs[7])}}, $past(br_ofs), 1'b0}));

    a_r5_r6_jump: assert property (@(posedge clk) disable iff (rst)
        (en && jmp) |=> pc == {$past(jmp_addr[15:1]), 1'b0});

    a_r7_even: assert property (@(posedge clk) disable iff (rst)
        pc[0] == 1'b0);

    a_r8_quiet_chain: assert property (@(posedge clk) disable iff (rst)
        load_path |-> chain_carry == 16'h0000);

    a_r6_load_sel: assert property (@(posedge clk) disable iff (rst)
        jmp |-> load_path);

endmodule

bind pc_sequencer pcseq_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .br_take     (br_take),
    .br_ofs      (br_ofs),
    .jmp         (jmp),
    .jmp_addr    (jmp_addr),
    .pc          (pc),
    .load_path   (load_path),
    .chain_carry (chain_carry)
);

// File: tb/pc_sequencer_test.sv
module pc_sequencer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        br_take = 1'b0;
    logic [7:0]  br_ofs = 8'h00;
    logic        jmp = 1'b0;
    logic [15:0] jmp_addr = 16'h0000;
    logic [15:0] pc;

    int checks = 0;
    int failures = 0;
    logic [15:0] exp_pc = 16'h0000;

    always #5 clk = ~clk;

    pc_sequencer uut (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .br_take  (br_take),
        .br_ofs   (br_ofs),
        .jmp      (jmp),
        .jmp_addr (jmp_addr),
        .pc       (pc)
    );

    function automatic logic [15:0] model(input logic [15:0] cur, input logic e,
                                          input logic b, input logic [7:0] o,
                                          input logic j, input logic [15:0] t);
        logic [15:0] off;
        off = {{8{o[7]}}, o} <<< 1;
        if (!e)      return cur;
        else if (j)  return {t[15:1], 1'b0};
        else if (b)  return cur + off;
        else         return cur + 16'd2;
    endfunction

    task automatic check(input string req, input logic [15:0] exp);
        checks++;
        if (pc !== exp) begin
            failures++;
            $display("FAIL %s: pc=%h expected=%h", req, pc, exp);
        end
        checks++;
        if (pc[0] !== 1'b0) begin
            failures++;
            $display("FAIL R7: pc[0]=%b expected=0", pc[0]);
        end
    endtask

    // Called at a negedge; returns at the next negedge after one update.
    task automatic step(input string req, input logic e, input logic b,
                        input logic [7:0] o, input logic j, input logic [15:0] t);
        en = e; br_take = b; br_ofs = o; jmp = j; jmp_addr = t;
        exp_pc = model(exp_pc, e, b, o, j, t);
        @(posedge clk);
        @(negedge clk);
        check(req, exp_pc);
    endtask

    task automatic t_reset();
        rst = 1'b1; en = 1'b1; jmp = 1'b1; jmp_addr = 16'h1234;
        @(posedge clk);
        @(negedge clk);
        exp_pc = 16'h0000;
        check("R1", exp_pc);
        rst = 1'b0;
    endtask

    task automatic t_step();
        step("R3", 1, 0, 8'h00, 0, 16'h0);
        step("R3", 1, 0, 8'hFF, 0, 16'hFFFF);
        step("R3", 1, 0, 8'h00, 0, 16'h0);
    endtask

    task automatic t_branch();
        step("R5", 1, 0, 8'h00, 1, 16'h0400);
        step("R4 fwd max +254", 1, 1, 8'h7F, 0, 16'h0);
        step("R4 back max -256", 1, 1, 8'h80, 0, 16'h0);
        step("R4 -2", 1, 1, 8'hFF, 0, 16'h0);
        step("R4 zero", 1, 1, 8'h00, 0, 16'h0);
        step("R4 +10", 1, 1, 8'h05, 0, 16'h0);
    endtask

    task automatic t_jump();
        step("R5 odd target", 1, 0, 8'h00, 1, 16'h2345);
        step("R5 even target", 1, 0, 8'h00, 1, 16'h8000);
    endtask

    task automatic t_priority();
        step("R6 jmp over br", 1, 1, 8'h10, 1, 16'h0100);
        step("R6 br over step", 1, 1, 8'h10, 0, 16'h0);
    endtask

    task automatic t_hold();
        step("R2 hold jmp", 0, 0, 8'h00, 1, 16'hABCD);
        step("R2 hold br", 0, 1, 8'h40, 0, 16'h0);
        step("R2 hold step", 0, 0, 8'h00, 0, 16'h0);
    endtask

    task automatic t_wrap();
        step("R5", 1, 0, 8'h00, 1, 16'hFFFE);
        step("R9 step wrap", 1, 0, 8'h00, 0, 16'h0);
        step("R5", 1, 0, 8'h00, 1, 16'hFFFE);
        step("R9 branch wrap", 1, 1, 8'h01, 0, 16'h0);
        step("R9 branch under", 1, 1, 8'hFF, 0, 16'h0);
    endtask

    task automatic t_quiet_chain();
        step("R5", 1, 0, 8'h00, 1, 16'hFFFF);
        step("R8 load vs ones", 1, 1, 8'hFF, 1, 16'h5555);
        step("R5", 1, 0, 8'h00, 1, 16'hFFFE);
        step("R8 load alt", 1, 1, 8'h7F, 1, 16'hAAAB);
        step("R8 load zero", 1, 0, 8'h00, 1, 16'h0001);
    endtask

    task automatic t_reset_mid();
        step("R3", 1, 0, 8'h00, 0, 16'h0);
        rst = 1'b1; en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        exp_pc = 16'h0000;
        check("R1 mid-run", exp_pc);
        rst = 1'b0;
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog: run did not complete, pc=%h expected=%h", pc, exp_pc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        t_step();
        t_branch();
        t_jump();
        t_priority();
        t_hold();
        t_wrap();
        t_quiet_chain();
        t_reset_mid();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule